// File: doc/BRIEF.md
# Calorimeter 2x2 Cluster Finder

This block takes calorimeter trigger towers one eta column at a time. Every clock that carries a column brings N_PHI towers. Each tower has an electromagnetic energy, a hadronic energy and one flag bit for each of the two. The block first builds a combined tower: the energy is the sum of the two parts, and the veto is set when either flag is set. A tower whose combined energy is below a programmable threshold is cleared, so it adds no energy and no veto.

From the cleaned towers the block forms a 2x2 cluster at every tower position. The cluster anchored at column j and phi row p covers rows p and p+1 of columns j and j+1. Neighbouring clusters therefore share towers. The phi direction is a ring, so the anchor in the last row pairs with row 0. The clusters of one anchor column come out in parallel, one word per phi row, with a valid strobe. That strobe follows the arrival of column j+1 after a fixed delay.

A column marked as the first of a frame starts a new grid. It is never paired with the column before it. The threshold can only be changed while nothing is in flight.

Top module: `calo_cluster_finder`

## Requirements
- R1: The combined tower energy is the unsigned sum of the 8-bit electromagnetic and 8-bit hadronic energies, 9 bits wide, maximum 510.
- R2: The tower veto is the OR of the electromagnetic flag and the hadronic flag.
- R3: A tower whose combined energy is strictly below the threshold contributes energy 0 and veto 0. A tower equal to the threshold is kept.
- R4: `clu_et[p*11 +: 11]` is the sum of towers (j,p), (j,p+1), (j+1,p) and (j+1,p+1), 11 bits wide. The largest value, 2040, is exact.
- R5: Phi wraps around: the anchor in row N_PHI-1 uses row 0 as its second row.
- R6: `clu_veto[p]` is the OR of the vetoes of the four towers in cluster p.
- R7: Take an accepted column j+1 that is not marked `col_first` and that follows an earlier accepted column. `clu_valid` is high for exactly one cycle, two rising edges after the edge that accepts it. A column with `col_first` high, or the first column after reset, produces no cluster output.
- R8: A threshold write (`thr_wr`) is taken only when the block is idle: `col_valid` is low and no column is inside the pipeline. Otherwise it is ignored. An accepted value applies from the next column.
- R9: After reset `clu_valid` is low and the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| col_valid | input | 1 | A tower column is present this cycle |
| col_first | input | 1 | This column starts a new frame |
| ecal_et | input | N_PHI*8 | Electromagnetic energy of each phi row, row p at bits [p*8 +: 8] |
| ecal_fl | input | N_PHI | Electromagnetic flag of each row |
| hcal_et | input | N_PHI*8 | Hadronic energy of each phi row, row p at bits [p*8 +: 8] |
| hcal_fl | input | N_PHI | Hadronic flag of each row |
| thr_wr | input | 1 | Threshold write request |
| thr_val | input | 9 | New threshold value |
| clu_valid | output | 1 | Cluster column valid |
| clu_et | output | N_PHI*11 | Cluster energy of each anchor row, row p at bits [p*11 +: 11] |
| clu_veto | output | N_PHI | Cluster veto of each anchor row |

## Verification
The hardest case to reach is a threshold write that arrives while a column is still inside the pipeline but `col_valid` has already dropped, or while the stream is still running. The write must be refused there, and the only way to see that is the energies of later clusters. The bench issues a write to an extreme value during a back-to-back frame. It then sends a second frame whose towers sit between the old and the refused value, so an accepted write would clear them. The same frame restarts with `col_first` partway through, which shows that no cluster is formed across the frame boundary.

// File: rtl/calo_clu_pkg.sv
package calo_clu_pkg;
  // default geometry and widths of the cluster finder
  localparam int unsigned CAL_E_W   = 8;
  localparam int unsigned CAL_N_PHI = 8;
  localparam int unsigned CAL_TOW_W = CAL_E_W + 1;
  localparam int unsigned CAL_CLU_W = CAL_TOW_W + 2;

  // pipeline stage control word
  typedef struct packed {
    logic vld;
    logic first;
  } stg_ctl_t;
endpackage

// File: rtl/calo_tower_unit.sv
module calo_tower_unit #(
  parameter int unsigned E_W   = 8,
  parameter int unsigned TOW_W = E_W + 1
) (
  input  logic [E_W-1:0]   em_et,
  input  logic             em_fl,
  input  logic [E_W-1:0]   had_et,
  input  logic             had_fl,
  input  logic [TOW_W-1:0] thr,
  output logic [TOW_W-1:0] tow_et,
  output logic             tow_veto
);
  logic [TOW_W-1:0] raw_sum;
  logic             keep;

  always_comb begin
    raw_sum  = TOW_W'(em_et) + TOW_W'(had_et);
    keep     = (raw_sum >= thr);
    tow_et   = keep ? raw_sum : '0;
    tow_veto = keep & (em_fl | had_fl);
  end
endmodule

// File: rtl/calo_clu_adder.sv
module calo_clu_adder #(
  parameter int unsigned TOW_W = 9,
  parameter int unsigned CLU_W = TOW_W + 2
) (
  input  logic [TOW_W-1:0] a_lo,
  input  logic [TOW_W-1:0] a_hi,
  input  logic [TOW_W-1:0] b_lo,
  input  logic [TOW_W-1:0] b_hi,
  input  logic             va_lo,
  input  logic             va_hi,
  input  logic             vb_lo,
  input  logic             vb_hi,
  output logic [CLU_W-1:0] sum,
  output logic             veto
);
  logic [CLU_W-1:0] pair_a;
  logic [CLU_W-1:0] pair_b;

  always_comb begin
    pair_a = CLU_W'(a_lo) + CLU_W'(a_hi);
    pair_b = CLU_W'(b_lo) + CLU_W'(b_hi);
    sum    = pair_a + pair_b;
    veto   = va_lo | va_hi | vb_lo | vb_hi;
  end
endmodule

// File: rtl/calo_thr_ctrl.sv
module calo_thr_ctrl #(
  parameter int unsigned TOW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             wr_req,
  input  logic [TOW_W-1:0] wr_val,
  output logic [TOW_W-1:0] thr_q
);
  logic             thr_en;
  logic [TOW_W-1:0] thr_d;

  always_comb begin
    thr_en = wr_req & idle;
    thr_d  = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (thr_en) begin
      thr_q <= thr_d;
    end
  end
endmodule

// File: rtl/calo_cluster_finder.sv
module calo_cluster_finder
  import calo_clu_pkg::*;
#(
  parameter int unsigned N_PHI = CAL_N_PHI,
  parameter int unsigned E_W   = CAL_E_W,
  localparam int unsigned TOW_W = E_W + 1,
  localparam int unsigned CLU_W = TOW_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   col_valid,
  input  logic                   col_first,
  input  logic [N_PHI*E_W-1:0]   ecal_et,
  input  logic [N_PHI-1:0]       ecal_fl,
  input  logic [N_PHI*E_W-1:0]   hcal_et,
  input  logic [N_PHI-1:0]       hcal_fl,
  input  logic                   thr_wr,
  input  logic [TOW_W-1:0]       thr_val,
  output logic                   clu_valid,
  output logic [N_PHI*CLU_W-1:0] clu_et,
  output logic [N_PHI-1:0]       clu_veto
);
  // threshold
  logic             idle;
  logic [TOW_W-1:0] thr_q;

  // stage 0: combinational towers
  logic [TOW_W-1:0] tw_et   [N_PHI];
  logic             tw_veto [N_PHI];

  // stage 1: current column and previous column
  stg_ctl_t         s1_d, s1_q;
  logic [TOW_W-1:0] cur_et   [N_PHI];
  logic             cur_veto [N_PHI];
  logic [TOW_W-1:0] prv_et   [N_PHI];
  logic             prv_veto [N_PHI];
  logic             have_prv_d, have_prv_q;

  // stage 2: clusters
  logic             pair_go;
  logic             o_vld_d, o_vld_q;
  logic [CLU_W-1:0] cs_et   [N_PHI];
  logic             cs_veto [N_PHI];
  logic [CLU_W-1:0] o_et    [N_PHI];
  logic             o_veto  [N_PHI];

  calo_thr_ctrl #(.TOW_W(TOW_W)) i_thr (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle   (idle),
    .wr_req (thr_wr),
    .wr_val (thr_val),
    .thr_q  (thr_q)
  );

  for (genvar p = 0; p < N_PHI; p++) begin : g_tow
    calo_tower_unit #(.E_W(E_W), .TOW_W(TOW_W)) i_tow (
      .em_et    (ecal_et[p*E_W +: E_W]),
      .em_fl    (ecal_fl[p]),
      .had_et   (hcal_et[p*E_W +: E_W]),
      .had_fl   (hcal_fl[p]),
      .thr      (thr_q),
      .tow_et   (tw_et[p]),
      .tow_veto (tw_veto[p])
    );
  end

  // next-state control
  always_comb begin
    s1_d.vld   = col_valid;
    s1_d.first = col_first;
    have_prv_d = have_prv_q | s1_q.vld;
    pair_go    = s1_q.vld & ~s1_q.first & have_prv_q;
    o_vld_d    = pair_go;
    idle       = ~col_valid & ~s1_q.vld & ~o_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q       <= '0;
      have_prv_q <= 1'b0;
      o_vld_q    <= 1'b0;
    end else begin
      s1_q       <= s1_d;
      have_prv_q <= have_prv_d;
      o_vld_q    <= o_vld_d;
    end
  end

  // column data registers with explicit enables
  for (genvar p = 0; p < N_PHI; p++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_et[p]   <= '0;
        cur_veto[p] <= 1'b0;
      end else if (col_valid) begin
        cur_et[p]   <= tw_et[p];
        cur_veto[p] <= tw_veto[p];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prv_et[p]   <= '0;
        prv_veto[p] <= 1'b0;
      end else if (s1_q.vld) begin
        prv_et[p]   <= cur_et[p];
        prv_veto[p] <= cur_veto[p];
      end
    end
  end

  // cluster adders, phi index wraps at the ring end
  for (genvar p = 0; p < N_PHI; p++) begin : g_clu
    localparam int unsigned P_NXT = (p == N_PHI - 1) ? 0 : p + 1;

    calo_clu_adder #(.TOW_W(TOW_W), .CLU_W(CLU_W)) i_add (
      .a_lo  (prv_et[p]),
      .a_hi  (prv_et[P_NXT]),
      .b_lo  (cur_et[p]),
      .b_hi  (cur_et[P_NXT]),
      .va_lo (prv_veto[p]),
      .va_hi (prv_veto[P_NXT]),
      .vb_lo (cur_veto[p]),
      .vb_hi (cur_veto[P_NXT]),
      .sum   (cs_et[p]),
      .veto  (cs_veto[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        o_et[p]   <= '0;
        o_veto[p] <= 1'b0;
      end else if (pair_go) begin
        o_et[p]   <= cs_et[p];
        o_veto[p] <= cs_veto[p];
      end
    end

    assign clu_et[p*CLU_W +: CLU_W] = o_et[p];
    assign clu_veto[p]              = o_veto[p];
  end

  assign clu_valid = o_vld_q;
endmodule

// File: rtl/calo_cluster_finder_chk.sv
module calo_cluster_finder_chk #(
  parameter int unsigned N_PHI = 8,
  parameter int unsigned E_W   = 8,
  parameter int unsigned TOW_W = E_W + 1,
  parameter int unsigned CLU_W = TOW_W + 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   col_valid,
  input logic                   col_first,
  input logic                   thr_wr,
  input logic [TOW_W-1:0]       thr_val,
  input logic                   idle,
  input logic [TOW_W-1:0]       thr_q,
  input logic                   clu_valid,
  input logic [N_PHI*CLU_W-1:0] clu_et
);
  localparam int unsigned CLU_MAX = 4 * 2 * ((1 << E_W) - 1);

  // R7: a cluster column needs a column accepted two edges earlier
  a_r7_needs_column: assert property (@(posedge clk) disable iff (!rst_n)
    clu_valid |-> $past(col_valid, 2));

  // R7: a frame-opening column yields nothing
  a_r7_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(col_valid && col_first, 2) |-> !clu_valid);

  // R8: threshold holds while anything is in flight
  a_r8_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(thr_q));

  // R8: an idle write is taken
  a_r8_thr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && thr_wr) |=> (thr_q == $past(thr_val)));

  // R9: no output strobe in the first cycle out of reset
  a_r9_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !clu_valid);

  // R4: a cluster never exceeds four maximal towers
  always @(posedge clk) begin
    if (rst_n && clu_valid) begin
      for (int p = 0; p < N_PHI; p++) begin
        a_r4_sum_range: assert (int'(clu_et[p*CLU_W +: CLU_W]) <= CLU_MAX);
      end
    end
  end
endmodule

bind calo_cluster_finder calo_cluster_finder_chk #(
  .N_PHI (N_PHI),
  .E_W   (E_W),
  .TOW_W (TOW_W),
  .CLU_W (CLU_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .col_valid (col_valid),
  .col_first (col_first),
  .thr_wr    (thr_wr),
  .thr_val   (thr_val),
  .idle      (idle),
  .thr_q     (thr_q),
  .clu_valid (clu_valid),
  .clu_et    (clu_et)
);

// File: tb/test_calo_cluster_finder.sv
module test_calo_cluster_finder;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 8;
  localparam int EW   = 8;
  localparam int TW   = 9;
  localparam int CW   = 11;
  localparam int MAXC = 8;

  logic           clk;
  logic           rst_n;
  logic           col_valid, col_first;
  logic [NP*EW-1:0] ecal_et, hcal_et;
  logic [NP-1:0]  ecal_fl, hcal_fl;
  logic           thr_wr;
  logic [TW-1:0]  thr_val;
  logic           clu_valid;
  logic [NP*CW-1:0] clu_et;
  logic [NP-1:0]  clu_veto;

  int n_chk = 0;
  int n_err = 0;
  int cur_thr = 0;
  bit done = 0;

  int s_e  [MAXC][NP];
  int s_h  [MAXC][NP];
  bit s_ef [MAXC][NP];
  bit s_hf [MAXC][NP];
  bit s_first [MAXC];

  calo_cluster_finder i_calo_cluster_finder (
    .clk, .rst_n, .col_valid, .col_first, .ecal_et, .ecal_fl,
    .hcal_et, .hcal_fl, .thr_wr, .thr_val, .clu_valid, .clu_et, .clu_veto
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tow_e(int j, int p);
    int s = s_e[j][p] + s_h[j][p];
    return (s < cur_thr) ? 0 : s;
  endfunction

  function automatic int tow_v(int j, int p);
    int s = s_e[j][p] + s_h[j][p];
    return (s < cur_thr) ? 0 : int'(s_ef[j][p] | s_hf[j][p]);
  endfunction

  task automatic idle_inputs();
    col_valid = 0; col_first = 0; thr_wr = 0; thr_val = '0;
    ecal_et = '0; hcal_et = '0; ecal_fl = '0; hcal_fl = '0;
  endtask

  task automatic write_thr(input int v);
    @(negedge clk);
    thr_wr = 1; thr_val = TW'(v);
    @(negedge clk);
    thr_wr = 0;
    cur_thr = v;
  endtask

  // drive n columns back to back; check each output slot two edges later
  task automatic run_cols(input int n, input string tag, input int wr_at, input int wr_v);
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int j = i - 2;
        bit ev = (j >= 1) && !s_first[j];
        chk(clu_valid == ev, {tag, " R7 valid"}, int'(clu_valid), int'(ev));
        if (ev && clu_valid) begin
          for (int p = 0; p < NP; p++) begin
            int q = (p + 1) % NP;
            int es = tow_e(j-1,p) + tow_e(j-1,q) + tow_e(j,p) + tow_e(j,q);
            int evt = tow_v(j-1,p) | tow_v(j-1,q) | tow_v(j,p) | tow_v(j,q);
            int ae = int'(clu_et[p*CW +: CW]);
            chk(ae == es, {tag, " R4 sum"}, ae, es);
            chk(int'(clu_veto[p]) == evt, {tag, " R6 veto"}, int'(clu_veto[p]), evt);
          end
        end
      end
      if (i < n) begin
        col_valid = 1; col_first = s_first[i];
        for (int p = 0; p < NP; p++) begin
          ecal_et[p*EW +: EW] = EW'(s_e[i][p]);
          hcal_et[p*EW +: EW] = EW'(s_h[i][p]);
          ecal_fl[p] = s_ef[i][p];
          hcal_fl[p] = s_hf[i][p];
        end
      end else begin
        col_valid = 0; col_first = 0;
      end
      thr_wr  = (i == wr_at);
      thr_val = TW'(wr_v);
    end
    thr_wr = 0;
  endtask

  task automatic clear_stim();
    for (int j = 0; j < MAXC; j++) begin
      s_first[j] = (j == 0);
      for (int p = 0; p < NP; p++) begin
        s_e[j][p] = 0; s_h[j][p] = 0; s_ef[j][p] = 0; s_hf[j][p] = 0;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(clu_valid == 0, "R9 valid after reset", int'(clu_valid), 0);
  endtask

  // R1 R4 R5: distinct values per row make the wrap visible
  task automatic t_basic();
    clear_stim();
    for (int j = 0; j < 4; j++)
      for (int p = 0; p < NP; p++) begin
        s_e[j][p] = 10*j + p + 1; s_h[j][p] = 3*p;
      end
    s_e[1][0] = 200; s_h[2][0] = 150;
    run_cols(4, "R1 R5 basic", -1, 0);
  endtask

  // R2 R6: flags on single towers
  task automatic t_veto();
    clear_stim();
    for (int j = 0; j < 3; j++)
      for (int p = 0; p < NP; p++) s_e[j][p] = 5;
    s_ef[0][3] = 1; s_hf[1][7] = 1; s_ef[2][5] = 1; s_hf[2][5] = 1;
    run_cols(3, "R2 flags", -1, 0);
  endtask

  // R3: towers at threshold-1 vanish with their flag, at threshold stay
  task automatic t_thr();
    write_thr(20);
    clear_stim();
    for (int j = 0; j < 3; j++)
      for (int p = 0; p < NP; p++) begin
        s_e[j][p] = (p % 2) ? 10 : 9; s_h[j][p] = 10;
        s_ef[j][p] = 1;
      end
    run_cols(3, "R3 threshold", -1, 0);
  endtask

  // R8: write while busy is refused; R7: restart mid stream
  task automatic t_busy_write();
    clear_stim();
    for (int j = 0; j < 5; j++)
      for (int p = 0; p < NP; p++) begin
        s_e[j][p] = 30 + p; s_h[j][p] = 20;
      end
    s_first[2] = 1;
    run_cols(5, "R8 busy write", 2, 400);
    // refused write late in the pipeline after col_valid drops
    clear_stim();
    for (int j = 0; j < 2; j++)
      for (int p = 0; p < NP; p++) s_e[j][p] = 60;
    run_cols(2, "R8 tail write", 2, 450);
    clear_stim();
    for (int j = 0; j < 2; j++)
      for (int p = 0; p < NP; p++) s_e[j][p] = 100;
    run_cols(2, "R8 after refuse", -1, 0);
  endtask

  // R1 R4: full-scale towers
  task automatic t_max();
    write_thr(0);
    clear_stim();
    for (int j = 0; j < 2; j++)
      for (int p = 0; p < NP; p++) begin
        s_e[j][p] = 255; s_h[j][p] = 255;
      end
    run_cols(2, "R1 full scale", -1, 0);
    @(negedge clk);
    chk(clu_et[0 +: CW] == 11'd2040, "R4 max sum held", int'(clu_et[0 +: CW]), 2040);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_veto();
    t_thr();
    t_busy_write();
    t_max();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule